// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block passes data in both directions between an A port and a B port, organised as byte lanes that each carry their own control set. Every lane holds two storage latches back to back: one feeding the B side from A and one feeding the A side from B. Each direction has three active-low controls: an input enable, a latch enable and an output enable. Tying the control inputs of all lanes together makes the lanes act as one wide transceiver.

The latches are level-sensitive in function but built from registers on a system clock. While a direction's gate is open (input enable low and latch enable low), its output tracks its input in the same cycle, and the register samples the input at each clock edge. When the gate closes, the output shows the last sampled value. The port drivers appear as data plus a per-lane enable, and tristate resolution is left to the surrounding level. A power-good input disables every driver. A per-lane bus keeper supplies the last driven value of an input port that nobody drives.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: With a lane's A-to-B input enable and latch enable both low, the lane's B data equals its A data in the same cycle, without inversion.
- R2: When the A-to-B latch enable goes high while the input enable is low, B keeps showing the A value sampled at the last clock edge before the change, and later changes on A do not reach B.
- R3: While the A-to-B input enable is high, the stored A-to-B value is not updated, whatever the latch enable does. When the input enable returns low with the latch enable high, B shows the value stored before.
- R4: A lane's B enable output is high only when that lane's A-to-B input enable and output enable are both low and power-good is high. Otherwise the lane's B side is high impedance.
- R5: The B-to-A direction follows R1 to R4 with its own three controls, driving A from B.
- R6: Each lane responds only to its own control bits. Bit n of every control vector governs data bits 8n to 8n+7.
- R7: While power-good is low, every A and B enable output is low.
- R8: When a lane's external-drive flag for a port is low and the block is not driving that port, the lane uses the last value that was present on that port.
- R9: After reset, every stored value and every bus keeper holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples open latches and keepers |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Supply good; low disables all drivers |
| ien_ab_ni | input | NUM_LANES | A-to-B input enable per lane, active low |
| le_ab_ni | input | NUM_LANES | A-to-B latch enable per lane, active low |
| oe_ab_ni | input | NUM_LANES | A-to-B output enable per lane, active low |
| ien_ba_ni | input | NUM_LANES | B-to-A input enable per lane, active low |
| le_ba_ni | input | NUM_LANES | B-to-A latch enable per lane, active low |
| oe_ba_ni | input | NUM_LANES | B-to-A output enable per lane, active low |
| a_i | input | NUM_LANES*LANE_W | Value seen on the A bus |
| a_drv_i | input | NUM_LANES | Per lane, an external source drives A |
| a_o | output | NUM_LANES*LANE_W | Data the block drives onto A |
| a_oe_o | output | NUM_LANES | Per lane A driver enable |
| b_i | input | NUM_LANES*LANE_W | Value seen on the B bus |
| b_drv_i | input | NUM_LANES | Per lane, an external source drives B |
| b_o | output | NUM_LANES*LANE_W | Data the block drives onto B |
| b_oe_o | output | NUM_LANES | Per lane B driver enable |

## Verification
The hardest case to reach is a capture blocked by a high input enable. From the ports it looks exactly like a disabled output, so it shows up only after the input enable is lowered again with the latch enable still high. The stimulus stores a known word, raises the input enable, pulses the latch enable low while A carries a different word, and then reopens the input enable alone, so the older word must come back on B. The keeper is checked the same way: a word is driven, the drive flag is released while the bench's copy of A changes, and B is then observed through an open latch.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic ien_n;
    logic le_n;
    logic oe_n;
  } dir_ctrl_t;
endpackage

// File: rtl/xcvr_bus_hold.sv
module xcvr_bus_hold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         drv_i,
  input  logic [W-1:0] pin_i,
  input  logic         self_oe_i,
  input  logic [W-1:0] self_data_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0] keep_q;

  assign data_o = drv_i ? pin_i : keep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        keep_q <= '0;
    else if (drv_i)     keep_q <= pin_i;
    else if (self_oe_i) keep_q <= self_data_i;
  end

  // R8
  keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drv_i && !self_oe_i) ##1 !drv_i |-> $stable(data_o));
endmodule

// File: rtl/xcvr_dir_latch.sv
module xcvr_dir_latch
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  dir_ctrl_t    ctrl_i,
  input  logic         pwr_good_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o,
  output logic         oe_o
);
  logic         gate_open;
  logic [W-1:0] store_q;

  assign gate_open = !ctrl_i.ien_n && !ctrl_i.le_n;
  assign data_o    = gate_open ? data_i : store_q;
  assign oe_o      = pwr_good_i && !ctrl_i.ien_n && !ctrl_i.oe_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        store_q <= '0;
    else if (gate_open) store_q <= data_i;
  end

  // R2
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_open |=> store_q == $past(data_i));
  // R3
  closed_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_open |=> $stable(store_q));
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pwr_good_i,
  input  dir_ctrl_t    ab_ctrl_i,
  input  dir_ctrl_t    ba_ctrl_i,
  input  logic [W-1:0] a_i,
  input  logic         a_drv_i,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_i,
  input  logic         b_drv_i,
  output logic [W-1:0] b_o,
  output logic         b_oe_o
);
  logic [W-1:0] a_eff, b_eff;

  xcvr_bus_hold #(.W(W)) u_hold_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .drv_i(a_drv_i), .pin_i(a_i),
    .self_oe_i(a_oe_o), .self_data_i(a_o), .data_o(a_eff));

  xcvr_bus_hold #(.W(W)) u_hold_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .drv_i(b_drv_i), .pin_i(b_i),
    .self_oe_i(b_oe_o), .self_data_i(b_o), .data_o(b_eff));

  xcvr_dir_latch #(.W(W)) u_ab (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ab_ctrl_i), .pwr_good_i(pwr_good_i),
    .data_i(a_eff), .data_o(b_o), .oe_o(b_oe_o));

  xcvr_dir_latch #(.W(W)) u_ba (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ba_ctrl_i), .pwr_good_i(pwr_good_i),
    .data_i(b_eff), .data_o(a_o), .oe_o(a_oe_o));

  // R4
  b_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ab_ctrl_i.ien_n || ab_ctrl_i.oe_n) |-> !b_oe_o);
  // R5
  a_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ba_ctrl_i.ien_n || ba_ctrl_i.oe_n) |-> !a_oe_o);
endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr
  import xcvr_pkg::*;
#(
  parameter int LANE_W    = 8,
  parameter int NUM_LANES = 2,
  localparam int BUS_W    = LANE_W * NUM_LANES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pwr_good_i,
  input  logic [NUM_LANES-1:0] ien_ab_ni,
  input  logic [NUM_LANES-1:0] le_ab_ni,
  input  logic [NUM_LANES-1:0] oe_ab_ni,
  input  logic [NUM_LANES-1:0] ien_ba_ni,
  input  logic [NUM_LANES-1:0] le_ba_ni,
  input  logic [NUM_LANES-1:0] oe_ba_ni,
  input  logic [BUS_W-1:0]     a_i,
  input  logic [NUM_LANES-1:0] a_drv_i,
  output logic [BUS_W-1:0]     a_o,
  output logic [NUM_LANES-1:0] a_oe_o,
  input  logic [BUS_W-1:0]     b_i,
  input  logic [NUM_LANES-1:0] b_drv_i,
  output logic [BUS_W-1:0]     b_o,
  output logic [NUM_LANES-1:0] b_oe_o
);
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    dir_ctrl_t ab_ctrl, ba_ctrl;
    assign ab_ctrl = '{ien_n: ien_ab_ni[l], le_n: le_ab_ni[l], oe_n: oe_ab_ni[l]};
    assign ba_ctrl = '{ien_n: ien_ba_ni[l], le_n: le_ba_ni[l], oe_n: oe_ba_ni[l]};

    xcvr_lane #(.W(LANE_W)) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pwr_good_i (pwr_good_i),
      .ab_ctrl_i  (ab_ctrl),
      .ba_ctrl_i  (ba_ctrl),
      .a_i        (a_i[l*LANE_W +: LANE_W]),
      .a_drv_i    (a_drv_i[l]),
      .a_o        (a_o[l*LANE_W +: LANE_W]),
      .a_oe_o     (a_oe_o[l]),
      .b_i        (b_i[l*LANE_W +: LANE_W]),
      .b_drv_i    (b_drv_i[l]),
      .b_o        (b_o[l*LANE_W +: LANE_W]),
      .b_oe_o     (b_oe_o[l])
    );
  end

  // R7
  pwr_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |-> (a_oe_o == '0 && b_oe_o == '0));
endmodule

// File: tb/bidir_latch_xcvr_test.sv
`timescale 1ns/1ps
module bidir_latch_xcvr_test;
  localparam int LW = 8;
  localparam int NL = 2;
  localparam int BW = LW * NL;
  localparam int NV = 10;

  // {ien, le, oe, a_val, exp_b, exp_oe}, controls ganged across both lanes
  localparam logic [35:0] VEC [NV] = '{
    {3'b000, 16'h1234, 16'h1234, 1'b1},  // R1 transparent
    {3'b000, 16'hABCD, 16'hABCD, 1'b1},  // R1 follows
    {3'b010, 16'h5555, 16'hABCD, 1'b1},  // R2 captured
    {3'b010, 16'h0F0F, 16'hABCD, 1'b1},  // R2 hold
    {3'b011, 16'h0F0F, 16'h0000, 1'b0},  // R4 oe high
    {3'b110, 16'h0F0F, 16'h0000, 1'b0},  // R4 ien high
    {3'b100, 16'h7777, 16'h0000, 1'b0},  // R3 no capture
    {3'b110, 16'h7777, 16'h0000, 1'b0},  // R3
    {3'b010, 16'h7777, 16'hABCD, 1'b1},  // R3 old value back
    {3'b000, 16'h8001, 16'h8001, 1'b1}   // R1
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good;
  logic [NL-1:0] ien_ab, le_ab, oe_ab, ien_ba, le_ba, oe_ba;
  logic [NL-1:0] a_drv, b_drv, a_oe, b_oe;
  logic [BW-1:0] a_val, b_val, a_out, b_out;
  wire  [BW-1:0] a_bus, b_bus;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  for (genvar l = 0; l < NL; l++) begin : g_bus
    assign a_bus[l*LW +: LW] = a_drv[l] ? a_val[l*LW +: LW] : {LW{1'bz}};
    assign a_bus[l*LW +: LW] = a_oe[l]  ? a_out[l*LW +: LW] : {LW{1'bz}};
    assign b_bus[l*LW +: LW] = b_drv[l] ? b_val[l*LW +: LW] : {LW{1'bz}};
    assign b_bus[l*LW +: LW] = b_oe[l]  ? b_out[l*LW +: LW] : {LW{1'bz}};
  end

  bidir_latch_xcvr #(.LANE_W(LW), .NUM_LANES(NL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pwr_good),
    .ien_ab_ni(ien_ab), .le_ab_ni(le_ab), .oe_ab_ni(oe_ab),
    .ien_ba_ni(ien_ba), .le_ba_ni(le_ba), .oe_ba_ni(oe_ba),
    .a_i(a_bus), .a_drv_i(a_drv), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_bus), .b_drv_i(b_drv), .b_o(b_out), .b_oe_o(b_oe));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply at falling edge, sample mid low phase
  task automatic settle();
    @(negedge clk);
  endtask

  task automatic sample();
    #5;
  endtask

  initial begin
    pwr_good = 1'b1;
    ien_ab = '0; le_ab = '1; oe_ab = '0;
    ien_ba = '1; le_ba = '1; oe_ba = '1;
    a_drv = '1; b_drv = '0; a_val = 16'h0000; b_val = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    sample();
    check("R9 reset store", 32'(b_bus), 32'h0000);
    check("R9 reset oe", 32'(b_oe), 32'h3);

    for (int i = 0; i < NV; i++) begin
      settle();
      ien_ab = {NL{VEC[i][35]}};
      le_ab  = {NL{VEC[i][34]}};
      oe_ab  = {NL{VEC[i][33]}};
      a_val  = VEC[i][32:17];
      sample();
      check("R4 table oe", 32'(b_oe), VEC[i][0] ? 32'h3 : 32'h0);
      if (VEC[i][0]) check("R1/R2/R3 table data", 32'(b_bus), 32'(VEC[i][16:1]));
    end

    // R6 lane 1 latched (holds 80), lane 0 transparent
    settle();
    le_ab = 2'b10; a_val = 16'h1357;
    sample();
    check("R6 lane split", 32'(b_bus), 32'h8057);

    // R8 bus keeper
    settle();
    le_ab = 2'b00; a_val = 16'h3C3C;
    sample();
    check("R8 driven", 32'(b_bus), 32'h3C3C);
    settle();
    a_drv = 2'b00; a_val = 16'hFFFF;
    sample();
    check("R8 undriven keeps", 32'(b_bus), 32'h3C3C);

    // R7 power-good low
    settle();
    pwr_good = 1'b0; ien_ba = '0; oe_ba = '0;
    sample();
    check("R7 b off", 32'(b_oe), 32'h0);
    check("R7 a off", 32'(a_oe), 32'h0);
    settle();
    pwr_good = 1'b1;
    ien_ab = '1; oe_ab = '1; ien_ba = '1; oe_ba = '1;

    // R5 B-to-A
    settle();
    b_drv = 2'b11; b_val = 16'hC0DE;
    ien_ba = '0; le_ba = '0; oe_ba = '0;
    sample();
    check("R5 transparent", 32'(a_bus), 32'hC0DE);
    check("R5 oe", 32'(a_oe), 32'h3);
    settle();
    le_ba = '1; b_val = 16'h1111;
    sample();
    check("R5 captured", 32'(a_bus), 32'hC0DE);
    settle();
    oe_ba = 2'b01;
    sample();
    check("R5 lane0 off", 32'(a_oe), 32'h2);
    check("R6 lane1 still drives", 32'(a_bus[15:8]), 32'hC0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule